// File: doc/BRIEF.md
# Power-Management Event and Interval Timer Block

This block holds the event status and event enable registers of a power-management event group together with a free-running interval counter. All of them sit behind a small byte-addressed I/O bus. Software reads the counter to measure elapsed time. It reads the status register to learn which event fired and writes ones to acknowledge events. A single level-sensitive interrupt line stays high while any implemented event is both pending and enabled.

Three events are modelled. The first is a timer event, raised each time the counter's top bit changes. The second is a power-button event and the third is a global event; both arrive as single-cycle hardware pulses. The counter advances once for every cycle in which the tick-enable input is high. The intended tick rate is about 3.58 MHz.

Each bus access lasts one cycle and is marked by a read or write strobe. The access carries an address and a byte count of 1, 2 or 4. Read data and the error flag are registered and appear in the cycle after the strobe.

Top module: `pm_evt_timer`

## Requirements
- R1: Only status bits 0 (timer event), 5 (power-button event) and 8 (global event) are stored. Every other status bit always reads as 0.
- R2: The enable register is 16 bits wide and fully readable and writable. Bits 0, 5 and 8 enable the timer, power-button and global events.
- R3: `sci` is high exactly when (status AND enable AND 0x0121) is nonzero. It follows every register write and status change in the cycle right after the clock edge that makes the change.
- R4: The event group occupies byte offsets 0..3 from `EVT_BASE`. Status is at offsets 0..1 and enable at offsets 2..3, little-endian, so a 4-byte read at offset 0 returns {enable, status}. A read of N bytes starts at the addressed offset, and bytes past offset 3 read as 0. Read data is valid one cycle after the strobe and is 0 in every other cycle.
- R5: Writes are applied byte by byte. A byte landing at offset 0 or 1 clears each status bit for which its data bit is 1. A byte landing at offset 2 or 3 replaces that enable byte. Bytes past offset 3 are dropped.
- R6: The counter is read with a 4-byte access at `TMR_BASE`. A 4-byte write there is accepted without error and changes nothing.
- R7: The counter increments by one, modulo 2^TMR_W (TMR_W = 32 by default), at each clock edge where `tick_en` is high. It holds otherwise. It reads zero-extended to 32 bits.
- R8: Whenever the counter's top bit changes, from 0 to 1 or from 1 to 0, status bit 0 is set at that same edge.
- R9: After reset, the counter, status, enable, `rdata`, `bus_err` and `sci` are all 0.
- R10: A pulse on `pwrbtn_evt` sets status bit 5 and a pulse on `global_evt` sets status bit 8. A hardware set wins over a software clear of the same bit in the same cycle.
- R11: An access is in error when it has a size other than 1, 2 or 4, when it is a non-4-byte access at `TMR_BASE`, or when both strobes are high. Such an access raises `bus_err` for the one following cycle, returns read data 0 and changes no register.
- R12: An access to any other address reads 0, raises no error and changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Counter advance enable, one cycle per tick |
| pwrbtn_evt | input | 1 | Power-button event pulse |
| global_evt | input | 1 | Global event pulse |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_size | input | 3 | Byte count of the access (1, 2 or 4) |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data, least significant byte to the addressed offset |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Registered error flag for the previous access |
| sci | output | 1 | Level-sensitive event interrupt |

## Verification
Read data and the error flag are due one cycle after the strobe. Register contents, the counter and the interrupt level all change at the clock edge that samples the write, tick or event pulse, so `sci` already shows the new level before the next edge. The bench drives its inputs on falling edges. Its model updates at each rising edge in the same order the requirements give: old values are read out first, then clears are applied, then hardware sets. The bench compares `sci`, `bus_rdata` and `bus_err` at every following falling edge, and each directed access samples its result at the falling edge after its strobe.

// File: rtl/pm_evt_pkg.sv
// Shared constants and helpers for the power-management event/timer block.
// Assumes byte lanes are little-endian and that sizes are byte counts.
package pm_evt_pkg;

    localparam int BIT_TMR = 0;
    localparam int BIT_PWR = 5;
    localparam int BIT_GBL = 8;

    localparam logic [15:0] EVT_MASK = (16'h1 << BIT_TMR) | (16'h1 << BIT_PWR) | (16'h1 << BIT_GBL);

    // Decoded view of one bus access.
    typedef struct packed {
        logic       err;
        logic       rd_ok;
        logic       wr_ok;
        logic       evt_hit;
        logic       tmr_hit;
        logic [1:0] off;
    } acc_t;

    // True when the byte count is one the bus supports.
    function automatic logic size_legal(input logic [2:0] sz);
        return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    endfunction

    // Byte-lane mask of an access starting at lane 0.
    function automatic logic [3:0] size_lanes(input logic [2:0] sz);
        case (sz)
            3'd1:    return 4'b0001;
            3'd2:    return 4'b0011;
            3'd4:    return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/pm_bus_decode.sv
// Decodes one bus access into legality, target window and per-byte write lanes.
// Assumes the event window is four bytes from EVT_A and the counter is one word at TMR_A.
module pm_bus_decode
    import pm_evt_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int unsigned EVT_BASE = 'h40,
    parameter int unsigned TMR_BASE = 'h48
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    input  logic              rd,
    input  logic              wr,
    input  logic [31:0]       wdata,
    output acc_t              acc,
    output logic [3:0]        lane_we,
    output logic [31:0]       lane_data
);

    localparam logic [ADDR_W-1:0] EVT_A = EVT_BASE[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] TMR_A = TMR_BASE[ADDR_W-1:0];

    logic [ADDR_W-1:0] off_full;
    logic              any_strobe;
    logic              bad;
    logic [7:0]        lanes_wide;
    logic [63:0]       data_wide;

    // Classify the access and flag illegal combinations.
    always_comb begin
        off_full    = addr - EVT_A;
        any_strobe  = rd | wr;
        acc.evt_hit = (off_full < ADDR_W'(4));
        acc.tmr_hit = (addr == TMR_A);
        acc.off     = off_full[1:0];
        bad         = any_strobe &&
                      ((rd && wr) || !size_legal(size) || (acc.tmr_hit && size != 3'd4));
        acc.err     = bad;
        acc.rd_ok   = rd && !bad;
        acc.wr_ok   = wr && !bad;
    end

    // Steer write bytes onto the lanes of the event window.
    always_comb begin
        lanes_wide = {4'b0000, size_lanes(size)} << acc.off;
        data_wide  = {32'h0, wdata} << {acc.off, 3'b000};
        lane_we    = (acc.wr_ok && acc.evt_hit) ? lanes_wide[3:0] : 4'b0000;
        lane_data  = data_wide[31:0];
    end

endmodule

// File: rtl/pm_evt_regs.sv
// Status (write-one-to-clear, hardware set) and enable registers of the event group.
// Assumes lane_we/lane_data are already aligned to offsets 0..3; hardware set wins over clear.
module pm_evt_regs
    import pm_evt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  lane_we,
    input  logic [31:0] lane_data,
    input  logic        set_tmr,
    input  logic        set_pwr,
    input  logic        set_gbl,
    output logic [15:0] sts,
    output logic [15:0] en
);

    logic [15:0] hw_set;

    // Gather the hardware set requests onto their bit positions.
    always_comb begin
        hw_set          = 16'h0;
        hw_set[BIT_TMR] = set_tmr;
        hw_set[BIT_PWR] = set_pwr;
        hw_set[BIT_GBL] = set_gbl;
    end

    for (genvar i = 0; i < 16; i++) begin : g_sts
        if (EVT_MASK[i]) begin : g_impl
            // Hold one implemented status bit: set by hardware, cleared by a written one.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    sts[i] <= 1'b0;
                else if (hw_set[i])
                    sts[i] <= 1'b1;
                else if (lane_we[i / 8] && lane_data[i])
                    sts[i] <= 1'b0;
            end
        end else begin : g_none
            assign sts[i] = 1'b0;
        end
    end

    for (genvar b = 0; b < 2; b++) begin : g_en
        // Replace one enable byte when its lane is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                en[8*b +: 8] <= 8'h00;
            else if (lane_we[2 + b])
                en[8*b +: 8] <= lane_data[16 + 8*b +: 8];
        end
    end

endmodule

// File: rtl/pm_tmr_ctr.sv
// Free-running interval counter with a top-bit change indication.
// Assumes the top_flip output is consumed at the same edge that advances the count.
module pm_tmr_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] cnt,
    output logic         top_flip
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_next;

    // Compute the next count and whether its top bit differs.
    always_comb begin
        cnt_next = cnt + ONE;
        top_flip = tick && (cnt_next[W-1] != cnt[W-1]);
    end

    // Advance the count on each tick, wrapping modulo 2^W.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick)
            cnt <= cnt_next;
    end

endmodule

// File: rtl/pm_evt_timer.sv
// Top of the power-management event group and interval counter.
// Assumes single-cycle accesses; read data and error are registered, sci is a level.
module pm_evt_timer
    import pm_evt_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int          TMR_W    = 32,
    parameter int unsigned EVT_BASE = 'h40,
    parameter int unsigned TMR_BASE = 'h48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              pwrbtn_evt,
    input  logic              global_evt,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [2:0]        bus_size,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    output logic              sci
);

    acc_t             acc;
    logic [3:0]       lane_we;
    logic [31:0]      lane_data;
    logic [15:0]      sts_q;
    logic [15:0]      en_q;
    logic [TMR_W-1:0] tmr_cnt;
    logic             tmr_flip;
    logic [31:0]      cnt_ext;
    logic [31:0]      rd_word;
    logic [3:0]       rd_lanes;
    logic [31:0]      rd_mask;
    logic [31:0]      evt_shift;

    pm_bus_decode #(
        .ADDR_W  (ADDR_W),
        .EVT_BASE(EVT_BASE),
        .TMR_BASE(TMR_BASE)
    ) dec_i (
        .addr     (bus_addr),
        .size     (bus_size),
        .rd       (bus_rd),
        .wr       (bus_wr),
        .wdata    (bus_wdata),
        .acc      (acc),
        .lane_we  (lane_we),
        .lane_data(lane_data)
    );

    pm_tmr_ctr #(
        .W(TMR_W)
    ) ctr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_en),
        .cnt     (tmr_cnt),
        .top_flip(tmr_flip)
    );

    pm_evt_regs regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .lane_we  (lane_we),
        .lane_data(lane_data),
        .set_tmr  (tmr_flip),
        .set_pwr  (pwrbtn_evt),
        .set_gbl  (global_evt),
        .sts      (sts_q),
        .en       (en_q)
    );

    // Drive the interrupt level from pending and enabled events.
    assign sci = |(sts_q & en_q & EVT_MASK);

    // Select the word a legal read returns.
    always_comb begin
        cnt_ext   = 32'(tmr_cnt);
        rd_lanes  = size_lanes(bus_size);
        rd_mask   = {{8{rd_lanes[3]}}, {8{rd_lanes[2]}}, {8{rd_lanes[1]}}, {8{rd_lanes[0]}}};
        evt_shift = {en_q, sts_q} >> {acc.off, 3'b000};
        rd_word   = 32'h0;
        if (acc.rd_ok && acc.evt_hit)
            rd_word = evt_shift & rd_mask;
        else if (acc.rd_ok && acc.tmr_hit)
            rd_word = cnt_ext;
    end

    // Register the response of this cycle's access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= 32'h0;
            bus_err   <= 1'b0;
        end else begin
            bus_rdata <= rd_word;
            bus_err   <= acc.err;
        end
    end

endmodule

// File: rtl/pm_evt_timer_chk.sv
// Property checker for pm_evt_timer, bound to every instance of the top.
// Assumes it sees the counter, status and enable state through the bind.
module pm_evt_timer_chk #(
    parameter int          ADDR_W   = 8,
    parameter int          TMR_W    = 32,
    parameter int unsigned TMR_BASE = 'h48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              pwrbtn_evt,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [2:0]        bus_size,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              bus_err,
    input logic              sci,
    input logic [TMR_W-1:0]  cnt,
    input logic [15:0]       sts,
    input logic [15:0]       en
);

    logic past_ok;
    logic bad_acc;

    // Mark cycles that have a valid previous cycle since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // Recognise an access the bus must reject.
    always_comb begin
        bad_acc = (bus_rd || bus_wr) &&
                  ((bus_rd && bus_wr) ||
                   !(bus_size == 3'd1 || bus_size == 3'd2 || bus_size == 3'd4) ||
                   (bus_addr == TMR_BASE[ADDR_W-1:0] && bus_size != 3'd4));
    end

    AST_ERR_ON_BAD:   assert property (@(posedge clk) disable iff (!rst_n) bad_acc |=> bus_err);   // R11
    AST_ERR_ONLY_BAD: assert property (@(posedge clk) disable iff (!rst_n) !bad_acc |=> !bus_err); // R11
    AST_CNT_HOLD:     assert property (@(posedge clk) disable iff (!rst_n) !tick_en |=> $stable(cnt)); // R7
    AST_CNT_STEP:     assert property (@(posedge clk) disable iff (!rst_n)
                          tick_en |=> cnt == TMR_W'($past(cnt) + 1'b1));                            // R7
    AST_TOP_FLIP:     assert property (@(posedge clk) disable iff (!rst_n)
                          (past_ok && cnt[TMR_W-1] != $past(cnt[TMR_W-1])) |-> sts[0]);             // R8
    AST_PWR_SCI:      assert property (@(posedge clk) disable iff (!rst_n)
                          (pwrbtn_evt && en[5] && !bus_wr) |=> sci);                                // R10
    AST_SCI_NO_EN:    assert property (@(posedge clk) disable iff (!rst_n)
                          ((en & 16'h0121) == 16'h0) |-> !sci);                                     // R3

endmodule

bind pm_evt_timer pm_evt_timer_chk #(
    .ADDR_W  (ADDR_W),
    .TMR_W   (TMR_W),
    .TMR_BASE(TMR_BASE)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .pwrbtn_evt(pwrbtn_evt),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_err   (bus_err),
    .sci       (sci),
    .cnt       (tmr_cnt),
    .sts       (sts_q),
    .en        (en_q)
);

// File: tb/pm_evt_timer_tb_top.sv
// Self-checking bench: behavioural model compared every cycle plus directed checks.
module pm_evt_timer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TW         = 10;
    localparam logic [7:0] EVT = 8'h40;
    localparam logic [7:0] TMR = 8'h48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        pwrbtn_evt = 1'b0;
    logic        global_evt = 1'b0;
    logic [7:0]  bus_addr = 8'h0;
    logic [2:0]  bus_size = 3'd0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        sci;

    int n_cmp = 0;
    int n_bad = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    // Behavioural model state
    int unsigned m_cnt;
    bit [15:0]   m_sts, m_en;
    bit [31:0]   m_rdata;
    bit          m_err;
    string       m_tag = "R9";

    always #(CLK_PERIOD/2) clk = ~clk;

    pm_evt_timer #(.ADDR_W(8), .TMR_W(TW), .EVT_BASE('h40), .TMR_BASE('h48)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pwrbtn_evt(pwrbtn_evt),
        .global_evt(global_evt), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .sci(sci)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model: response from old state, then clears, then hardware sets.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_sts = 0; m_en = 0; m_rdata = 0; m_err = 0; m_tag = "R9";
        end else begin
            bit [7:0] off8;
            bit evt, tmr, bad;
            int sz;
            bit [31:0] rv;
            off8 = bus_addr - EVT;
            evt  = off8 < 4;
            tmr  = bus_addr == TMR;
            sz   = int'(bus_size);
            bad  = (bus_rd || bus_wr) &&
                   ((bus_rd && bus_wr) || !(sz == 1 || sz == 2 || sz == 4) || (tmr && sz != 4));
            rv = 0;
            if (bus_rd && !bad) begin
                if (evt) begin
                    for (int i = 0; i < sz; i++) begin
                        int idx;
                        bit [7:0] bv;
                        idx = int'(off8) + i;
                        bv = 0;
                        if (idx < 2)      bv = m_sts[8*idx +: 8];
                        else if (idx < 4) bv = m_en[8*(idx-2) +: 8];
                        rv |= 32'(bv) << (8*i);
                    end
                    m_tag = "R4";
                end else if (tmr) begin
                    rv = m_cnt;
                    m_tag = "R7";
                end else m_tag = "R12";
            end
            if (bad) m_tag = "R11";
            m_rdata = rv;
            m_err = bad;
            if (bus_wr && !bad && evt) begin
                for (int i = 0; i < sz; i++) begin
                    int idx;
                    bit [7:0] wb;
                    idx = int'(off8) + i;
                    wb = bus_wdata[8*i +: 8];
                    if (idx < 2)      m_sts[8*idx +: 8] &= ~wb;
                    else if (idx < 4) m_en[8*(idx-2) +: 8] = wb;
                end
            end
            if (tick_en) begin
                int unsigned nxt;
                nxt = (m_cnt + 1) % (1 << TW);
                if (((nxt >> (TW-1)) & 1) != ((m_cnt >> (TW-1)) & 1)) m_sts[0] = 1'b1;
                m_cnt = nxt;
            end
            if (pwrbtn_evt) m_sts[5] = 1'b1;
            if (global_evt) m_sts[8] = 1'b1;
            m_sts &= 16'h0121;
        end
    end

    // Compare all outputs with the model on every falling edge.
    always @(negedge clk) begin
        if (mon_on && !done) begin
            check("R3 sci", {31'h0, sci}, {31'h0, |(m_sts & m_en & 16'h0121)});
            check("R11 err", {31'h0, bus_err}, {31'h0, m_err});
            check({m_tag, " rdata"}, bus_rdata, m_rdata);
        end
    end

    task automatic bus_read(input logic [7:0] a, input logic [2:0] s,
                            output logic [31:0] d, output logic e);
        @(negedge clk); bus_addr = a; bus_size = s; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata; e = bus_err;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [2:0] s,
                             input logic [31:0] w, output logic e);
        @(negedge clk); bus_addr = a; bus_size = s; bus_wdata = w; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0; e = bus_err;
    endtask

    task automatic pulse(input bit p, input bit g);
        @(negedge clk); pwrbtn_evt = p; global_evt = g;
        @(negedge clk); pwrbtn_evt = 1'b0; global_evt = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk); tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        logic e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R9: reset state
        bus_read(EVT, 3'd4, d, e); check("R9 evt", d, 32'h0);
        bus_read(TMR, 3'd4, d, e); check("R9 tmr", d, 32'h0);
        check("R9 sci", {31'h0, sci}, 32'h0);

        // R2: enable register fully writable
        bus_write(EVT + 8'd2, 3'd2, 32'h0000FFFF, e);
        bus_read(EVT + 8'd2, 3'd2, d, e); check("R2 en", d, 32'h0000FFFF);

        // R10 and R3: power-button event raises the interrupt
        pulse(1'b1, 1'b0);
        bus_read(EVT, 3'd2, d, e); check("R10 pwr", d, 32'h00000020);
        check("R3 sci high", {31'h0, sci}, 32'h1);

        // R5: one-byte write-one-to-clear
        bus_write(EVT, 3'd1, 32'h00000020, e);
        check("R3 sci low", {31'h0, sci}, 32'h0);
        bus_read(EVT, 3'd2, d, e); check("R5 clr", d, 32'h0);

        // R1 and R4: implemented bits and byte views
        pulse(1'b1, 1'b1);
        bus_read(EVT, 3'd2, d, e);          check("R1 sts", d, 32'h00000120);
        bus_read(EVT, 3'd4, d, e);          check("R4 word", d, 32'hFFFF0120);
        bus_read(EVT + 8'd1, 3'd1, d, e);   check("R4 byte1", d, 32'h00000001);
        bus_read(EVT + 8'd3, 3'd4, d, e);   check("R4 tail", d, 32'h000000FF);
        bus_write(EVT + 8'd1, 3'd1, 32'h00000001, e);
        bus_read(EVT, 3'd2, d, e);          check("R5 hi byte", d, 32'h00000020);

        // R10: hardware set wins over a same-cycle clear
        @(negedge clk); bus_addr = EVT; bus_size = 3'd1; bus_wdata = 32'h20;
        bus_wr = 1'b1; pwrbtn_evt = 1'b1;
        @(negedge clk); bus_wr = 1'b0; pwrbtn_evt = 1'b0;
        bus_read(EVT, 3'd2, d, e); check("R10 prio", d, 32'h00000020);

        // R5: four-byte write clears status and loads enable
        bus_write(EVT, 3'd4, 32'h0001FFFF, e);
        bus_read(EVT, 3'd4, d, e); check("R5 word", d, 32'h00010000);

        // R11: illegal accesses flag an error and change nothing
        pulse(1'b1, 1'b0);
        bus_write(EVT, 3'd3, 32'hFFFFFFFF, e); check("R11 size3 err", {31'h0, e}, 32'h1);
        bus_read(EVT, 3'd4, d, e);             check("R11 no change", d, 32'h00010020);
        bus_read(TMR, 3'd2, d, e);             check("R11 tmr size", {31'h0, e}, 32'h1);
        check("R11 rdata zero", d, 32'h0);
        @(negedge clk); bus_addr = EVT; bus_size = 3'd4; bus_wdata = 32'hFFFFFFFF;
        bus_rd = 1'b1; bus_wr = 1'b1;
        @(negedge clk); bus_rd = 1'b0; bus_wr = 1'b0;
        check("R11 both strobes", {31'h0, bus_err}, 32'h1);
        bus_read(EVT, 3'd4, d, e); check("R11 still", d, 32'h00010020);

        // R12: unmapped address
        bus_write(8'h50, 3'd4, 32'hFFFFFFFF, e); check("R12 wr err", {31'h0, e}, 32'h0);
        bus_read(8'h50, 3'd4, d, e);             check("R12 rd", d, 32'h0);
        check("R12 rd err", {31'h0, e}, 32'h0);

        // R6: counter writes are ignored without error
        bus_write(TMR, 3'd4, 32'hFFFFFFFF, e); check("R6 err", {31'h0, e}, 32'h0);
        bus_read(TMR, 3'd4, d, e);             check("R6 value", d, 32'h0);

        // R7: counting
        ticks(5);
        bus_read(TMR, 3'd4, d, e); check("R7 five", d, 32'd5);

        // R8: top bit rising sets timer status
        bus_write(EVT, 3'd4, 32'h0001FFFF, e);
        ticks(507);
        bus_read(EVT, 3'd2, d, e); check("R8 rise", d, 32'h00000001);
        check("R3 tmr sci", {31'h0, sci}, 32'h1);
        bus_read(TMR, 3'd4, d, e); check("R7 half", d, 32'd512);

        // R8 and R7: top bit falling on wrap
        bus_write(EVT, 3'd2, 32'h0000FFFF, e);
        bus_read(EVT, 3'd2, d, e); check("R5 tmr clr", d, 32'h0);
        ticks(512);
        bus_read(TMR, 3'd4, d, e); check("R7 wrap", d, 32'd0);
        bus_read(EVT, 3'd2, d, e); check("R8 fall", d, 32'h00000001);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule